// File: doc/BRIEF.md
# Integer Carry and Overflow Flag Unit

This unit sits beside an integer ALU and turns the operands and result of one completed operation into the fixed-point exception flags and the condition field. It needs none of the ALU's internals. For each valid operation it gets the register operands that were used and an optional immediate. The immediate is placed after the register operands as one more operand. It also gets the 64-bit result and a set of controls: whether the first operand was complemented, whether the operation belongs to the add family, and enables for carry, overflow and record updates.

Carry is found by comparing each operand, unsigned, against the result. There is a full-width compare and a low-half compare, and add-family operations use a parity rule at bit 32 for the half-width carry instead of the low-half compare. Overflow uses the classic sign rule on the first two operands, at the top bit and at bit 31. A divider can instead supply its own overflow value. Some operations produce their own carries. For these, a two-bit mask replaces the computed carry with the operation's own value. The summary overflow bit is sticky. With record enabled, a four-bit condition field is built from the sign of the result and the new summary bit.

All flags are registered and change on one rising clock edge when `valid_in` is high.

Top module: `int_flag_unit`

## Requirements
- R1: A low `rst_n` at a rising edge clears all five flag outputs and `cr0` to zero.
- R2: With `valid_in` low, no flag output and no bit of `cr0` changes.
- R3: When `invert_first` is set and at least one register operand is used, operand 0 is bitwise complemented before every carry and overflow evaluation.
- R4: With `carry_en` high, `flag_ca` becomes 1 exactly when any used operand slot is unsigned-greater than `result`. With `carry_en` low, `flag_ca` and `flag_ca32` keep their values.
- R5: For an add-family operation (`is_add` high), `flag_ca32` = result[32] XOR slot0[32] XOR slot1[32]. Slot 1 counts as 0 when fewer than two slots are used.
- R6: For other operations, `flag_ca32` becomes 1 exactly when the low 32 bits of any used slot are unsigned-greater than the low 32 bits of `result`.
- R7: When `carry_done[0]` is set, `flag_ca` takes `op_ca` instead of the computed value. When `carry_done[1]` is set, `flag_ca32` takes `op_ca32`. Both apply only with `carry_en` high.
- R8: `flag_ov` is 1 when slots 0 and 1 have equal bit 63 and the result's bit 63 differs from them. `flag_ov32` applies the same rule at bit 31.
- R9: When `divovf_valid` is high, both `flag_ov` and `flag_ov32` take `divovf_val` in place of the sign rule.
- R10: Overflow flags and the summary bit update only when `oe_bit` and `oe_valid` are both high, and there are at least two used slots or `divovf_valid` is high. Otherwise they hold.
- R11: The summary bit is sticky: `flag_so` becomes `flag_so` OR the new `flag_ov`, and once set it clears only by reset.
- R12: With `rec_en` high, `cr0` is loaded as {negative, positive, zero, summary}, with cr0[3] = negative and cr0[0] = summary. Negative, positive and zero come from `result` read as signed. The summary bit is the value written in the same update. With `rec_en` low, `cr0` holds.
- R13: Used register operands fill slots 0 up to `reg_cnt`-1 from `reg_opnds`, operand i at bits [64i+63:64i]. A valid immediate fills slot `reg_cnt` and takes part in every comparison and sign rule like a register operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | One operation's inputs are present this cycle |
| reg_opnds | input | 192 | Three register operands packed, operand i at bits [64i+63:64i] |
| reg_cnt | input | 2 | Number of register operands used (0 to 3) |
| imm_valid | input | 1 | Immediate operand present |
| imm_data | input | 64 | Immediate operand value |
| invert_first | input | 1 | Complement register operand 0 before evaluation |
| result | input | 64 | ALU result |
| is_add | input | 1 | Operation is in the add family |
| carry_en | input | 1 | Carry flags are to be updated |
| carry_done | input | 2 | Bit 0: the operation supplies CA, bit 1: it supplies CA32 |
| op_ca | input | 1 | Carry value produced by the operation |
| op_ca32 | input | 1 | Half-width carry produced by the operation |
| oe_bit | input | 1 | Overflow-enable field of the instruction |
| oe_valid | input | 1 | Overflow-enable field is meaningful |
| divovf_valid | input | 1 | Divider supplies the overflow value |
| divovf_val | input | 1 | Divider overflow value |
| rec_en | input | 1 | Record the condition field |
| flag_so | output | 1 | Sticky summary overflow |
| flag_ov | output | 1 | Overflow |
| flag_ov32 | output | 1 | Overflow at bit 31 |
| flag_ca | output | 1 | Carry |
| flag_ca32 | output | 1 | Carry at bit 32 |
| cr0 | output | 4 | Condition field {negative, positive, zero, summary} |

## Verification
Every flag and the condition field is due one rising edge after the cycle in which `valid_in` is high. No result appears in the same cycle and none comes later. The bench changes inputs on the falling edge and holds `valid_in` high for a single cycle. It reads the outputs at the next falling edge, which is half a period after the edge that loads them. For the hold requirements, the bench first puts known values in the registers. It then applies stimulus that would change them, with valid, an enable or the overflow qualifier withheld, and reads the registers again at the next falling edge.

// File: rtl/flag_pkg.sv
// Package: shared widths and condition-field bit positions for the flag unit.
// Assumes a 64-bit datapath with a half-width boundary at bit 32.
package flag_pkg;
    localparam int unsigned XLEN_DEF    = 64;
    localparam int unsigned NREG_DEF    = 3;

    // Bit positions inside the 4-bit condition field.
    localparam int unsigned CR_NEG  = 3;
    localparam int unsigned CR_POS  = 2;
    localparam int unsigned CR_ZERO = 1;
    localparam int unsigned CR_SUM  = 0;

    // Packed view of the computed flags before registering.
    typedef struct packed {
        logic ca;
        logic ca32;
        logic ov;
        logic ov32;
    } flag_calc_t;
endpackage

// File: rtl/flag_operand_prep.sv
// Operand preparation: places the used register operands in slots
// 0..reg_cnt-1 and the immediate (if any) in slot reg_cnt, complements
// register operand 0 when requested, and reports how many slots are used.
// Assumes reg_cnt never exceeds NREG.
module flag_operand_prep #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned NREG = 3,
    localparam int unsigned NSLOT = NREG + 1,
    localparam int unsigned CNTW  = $clog2(NREG + 1),
    localparam int unsigned TOTW  = $clog2(NSLOT + 1)
) (
    input  logic [NREG*XLEN-1:0]  reg_opnds,
    input  logic [CNTW-1:0]       reg_cnt,
    input  logic                  imm_valid,
    input  logic [XLEN-1:0]       imm_data,
    input  logic                  invert_first,
    output logic [NSLOT*XLEN-1:0] slot_val,
    output logic [NSLOT-1:0]      slot_used,
    output logic [TOTW-1:0]       slot_total
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic is_imm;
        assign is_imm = imm_valid && (reg_cnt == CNTW'(s));
        if (s < NREG) begin : g_reg
            logic          reg_used;
            logic [XLEN-1:0] reg_word;
            assign reg_used = (CNTW'(s) < reg_cnt);
            // Register word for this slot, complemented only for operand 0.
            always_comb begin
                reg_word = reg_opnds[s*XLEN +: XLEN];
                if (s == 0 && invert_first) reg_word = ~reg_word;
            end
            // Slot content: register operand, else immediate, else zero.
            always_comb begin
                if (reg_used)    slot_val[s*XLEN +: XLEN] = reg_word;
                else if (is_imm) slot_val[s*XLEN +: XLEN] = imm_data;
                else             slot_val[s*XLEN +: XLEN] = '0;
            end
            assign slot_used[s] = reg_used || is_imm;
        end else begin : g_tail
            // The last slot can only ever hold the immediate.
            assign slot_val[s*XLEN +: XLEN] = is_imm ? imm_data : '0;
            assign slot_used[s] = is_imm;
        end
    end

    assign slot_total = TOTW'(reg_cnt) + TOTW'(imm_valid);
endmodule

// File: rtl/flag_carry_eval.sv
// Carry evaluation: full-width carry from unsigned slot-versus-result
// compares; half-width carry from either the bit-32 parity rule (add
// family) or low-half unsigned compares. Assumes XLEN > 32.
module flag_carry_eval #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned NSLOT = 4,
    localparam int unsigned HALF = 32
) (
    input  logic [NSLOT*XLEN-1:0] slot_val,
    input  logic [NSLOT-1:0]      slot_used,
    input  logic [XLEN-1:0]       result,
    input  logic                  is_add,
    output logic                  ca,
    output logic                  ca32
);
    logic [NSLOT-1:0] gt_full;
    logic [NSLOT-1:0] gt_half;

    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        logic [XLEN-1:0] w;
        assign w = slot_val[s*XLEN +: XLEN];
        assign gt_full[s] = slot_used[s] && (w > result);
        assign gt_half[s] = slot_used[s] && (w[HALF-1:0] > result[HALF-1:0]);
    end

    logic par_a;
    logic par_b;
    assign par_a = slot_used[0] && slot_val[HALF];
    assign par_b = slot_used[1] && slot_val[XLEN + HALF];

    // Select the half-width carry rule by operation class.
    always_comb begin
        ca = |gt_full;
        if (is_add) ca32 = result[HALF] ^ par_a ^ par_b;
        else        ca32 = |gt_half;
    end
endmodule

// File: rtl/flag_overflow_eval.sv
// Overflow evaluation: sign rule on the first two slots at the top bit and
// at bit 31, with a divider-supplied override. Assumes the caller gates the
// result with the overflow enable and the operand-count condition.
module flag_overflow_eval #(
    parameter int unsigned XLEN = 64,
    localparam int unsigned HALF = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] result,
    input  logic            div_valid,
    input  logic            div_val,
    output logic            ov,
    output logic            ov32
);
    logic sign_ov;
    logic sign_ov32;
    assign sign_ov   = (op_a[XLEN-1] == op_b[XLEN-1]) && (result[XLEN-1] != op_a[XLEN-1]);
    assign sign_ov32 = (op_a[HALF-1] == op_b[HALF-1]) && (result[HALF-1] != op_a[HALF-1]);

    // Divider value overrides both sign-rule outcomes.
    always_comb begin
        if (div_valid) begin
            ov   = div_val;
            ov32 = div_val;
        end else begin
            ov   = sign_ov;
            ov32 = sign_ov32;
        end
    end
endmodule

// File: rtl/flag_cond_eval.sv
// Condition-field builder: negative/positive/zero from the signed result and
// the summary bit supplied by the caller (already including this update).
module flag_cond_eval #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] result,
    input  logic            sum_in,
    output logic [3:0]      cond
);
    import flag_pkg::*;
    logic is_zero;
    assign is_zero = (result == '0);

    // Pack the four condition bits at their fixed positions.
    always_comb begin
        cond          = '0;
        cond[CR_NEG]  = result[XLEN-1];
        cond[CR_POS]  = !result[XLEN-1] && !is_zero;
        cond[CR_ZERO] = is_zero;
        cond[CR_SUM]  = sum_in;
    end
endmodule

// File: rtl/int_flag_unit.sv
// Integer flag unit top: prepares operand slots, evaluates carry, overflow
// and the condition field, and registers the flags on a valid operation.
// Assumes synchronous active-low reset and one operation per valid cycle.
module int_flag_unit #(
    parameter int unsigned XLEN = flag_pkg::XLEN_DEF,
    parameter int unsigned NREG = flag_pkg::NREG_DEF,
    localparam int unsigned NSLOT = NREG + 1,
    localparam int unsigned CNTW  = $clog2(NREG + 1),
    localparam int unsigned TOTW  = $clog2(NSLOT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic [NREG*XLEN-1:0] reg_opnds,
    input  logic [CNTW-1:0]      reg_cnt,
    input  logic                 imm_valid,
    input  logic [XLEN-1:0]      imm_data,
    input  logic                 invert_first,
    input  logic [XLEN-1:0]      result,
    input  logic                 is_add,
    input  logic                 carry_en,
    input  logic [1:0]           carry_done,
    input  logic                 op_ca,
    input  logic                 op_ca32,
    input  logic                 oe_bit,
    input  logic                 oe_valid,
    input  logic                 divovf_valid,
    input  logic                 divovf_val,
    input  logic                 rec_en,
    output logic                 flag_so,
    output logic                 flag_ov,
    output logic                 flag_ov32,
    output logic                 flag_ca,
    output logic                 flag_ca32,
    output logic [3:0]           cr0
);
    import flag_pkg::*;

    logic [NSLOT*XLEN-1:0] slot_val;
    logic [NSLOT-1:0]      slot_used;
    logic [TOTW-1:0]       slot_total;
    flag_calc_t            calc;
    logic                  ov_go;
    logic                  so_next;
    logic [3:0]            cond_next;

    flag_operand_prep #(.XLEN(XLEN), .NREG(NREG)) u_prep (
        .reg_opnds    (reg_opnds),
        .reg_cnt      (reg_cnt),
        .imm_valid    (imm_valid),
        .imm_data     (imm_data),
        .invert_first (invert_first),
        .slot_val     (slot_val),
        .slot_used    (slot_used),
        .slot_total   (slot_total)
    );

    flag_carry_eval #(.XLEN(XLEN), .NSLOT(NSLOT)) u_carry (
        .slot_val  (slot_val),
        .slot_used (slot_used),
        .result    (result),
        .is_add    (is_add),
        .ca        (calc.ca),
        .ca32      (calc.ca32)
    );

    flag_overflow_eval #(.XLEN(XLEN)) u_ovf (
        .op_a      (slot_val[0 +: XLEN]),
        .op_b      (slot_val[XLEN +: XLEN]),
        .result    (result),
        .div_valid (divovf_valid),
        .div_val   (divovf_val),
        .ov        (calc.ov),
        .ov32      (calc.ov32)
    );

    // Overflow is evaluated only with a qualified enable and enough inputs.
    assign ov_go   = oe_bit && oe_valid && ((slot_total >= TOTW'(2)) || divovf_valid);
    // Summary bit as it will stand after this update, forwarded to cr0.
    assign so_next = ov_go ? (flag_so || calc.ov) : flag_so;

    flag_cond_eval #(.XLEN(XLEN)) u_cond (
        .result (result),
        .sum_in (so_next),
        .cond   (cond_next)
    );

    // Carry flags: computed or operation-supplied, under carry_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_ca   <= 1'b0;
            flag_ca32 <= 1'b0;
        end else if (valid_in && carry_en) begin
            flag_ca   <= carry_done[0] ? op_ca   : calc.ca;
            flag_ca32 <= carry_done[1] ? op_ca32 : calc.ca32;
        end
    end

    // Overflow flags and sticky summary bit, under the qualified enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_ov   <= 1'b0;
            flag_ov32 <= 1'b0;
            flag_so   <= 1'b0;
        end else if (valid_in && ov_go) begin
            flag_ov   <= calc.ov;
            flag_ov32 <= calc.ov32;
            flag_so   <= so_next;
        end
    end

    // Condition field, loaded only when recording.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cr0 <= '0;
        else if (valid_in && rec_en) cr0 <= cond_next;
    end
endmodule

// File: rtl/int_flag_unit_chk.sv
// Checker for int_flag_unit: temporal properties on its ports, bound below.
module int_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_in,
    input logic       carry_en,
    input logic [1:0] carry_done,
    input logic       op_ca,
    input logic       op_ca32,
    input logic       oe_bit,
    input logic       oe_valid,
    input logic       divovf_valid,
    input logic       divovf_val,
    input logic       rec_en,
    input logic       flag_so,
    input logic       flag_ov,
    input logic       flag_ov32,
    input logic       flag_ca,
    input logic       flag_ca32,
    input logic [3:0] cr0
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ({flag_so, flag_ov, flag_ov32, flag_ca, flag_ca32} == 5'b0 && cr0 == 4'b0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable({flag_so, flag_ov, flag_ov32, flag_ca, flag_ca32, cr0}));

    // R4
    carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !carry_en) |=> $stable({flag_ca, flag_ca32}));

    // R7
    done_ca_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && carry_en && carry_done[0]) |=> (flag_ca == $past(op_ca)));

    // R7
    done_ca32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && carry_en && carry_done[1]) |=> (flag_ca32 == $past(op_ca32)));

    // R9
    div_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && oe_bit && oe_valid && divovf_valid) |=>
        (flag_ov == $past(divovf_val) && flag_ov32 == $past(divovf_val)));

    // R10
    ov_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !(oe_bit && oe_valid)) |=> $stable({flag_so, flag_ov, flag_ov32}));

    // R11
    so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_so |=> flag_so);

    // R11
    so_follows_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ov) |-> flag_so);

    // R12
    cr0_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && rec_en) |=> (cr0[0] == flag_so && $countones(cr0[3:1]) == 1));

    // R12
    cr0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !rec_en) |=> $stable(cr0));
endmodule

bind int_flag_unit int_flag_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_in     (valid_in),
    .carry_en     (carry_en),
    .carry_done   (carry_done),
    .op_ca        (op_ca),
    .op_ca32      (op_ca32),
    .oe_bit       (oe_bit),
    .oe_valid     (oe_valid),
    .divovf_valid (divovf_valid),
    .divovf_val   (divovf_val),
    .rec_en       (rec_en),
    .flag_so      (flag_so),
    .flag_ov      (flag_ov),
    .flag_ov32    (flag_ov32),
    .flag_ca      (flag_ca),
    .flag_ca32    (flag_ca32),
    .cr0          (cr0)
);

// File: tb/tb_int_flag_unit.sv
`timescale 1ns/1ps
// Bench for int_flag_unit: a carry vector table walked by one loop, then
// directed tests for reset, gating, masks, overflow, summary and cr0.
module tb_int_flag_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [191:0] reg_opnds = '0;
    logic [1:0]   reg_cnt = '0;
    logic         imm_valid = 1'b0;
    logic [63:0]  imm_data = '0;
    logic         invert_first = 1'b0;
    logic [63:0]  result = '0;
    logic         is_add = 1'b0;
    logic         carry_en = 1'b0;
    logic [1:0]   carry_done = '0;
    logic         op_ca = 1'b0;
    logic         op_ca32 = 1'b0;
    logic         oe_bit = 1'b0;
    logic         oe_valid = 1'b0;
    logic         divovf_valid = 1'b0;
    logic         divovf_val = 1'b0;
    logic         rec_en = 1'b0;
    logic         flag_so, flag_ov, flag_ov32, flag_ca, flag_ca32;
    logic [3:0]   cr0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    int_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .reg_opnds(reg_opnds),
        .reg_cnt(reg_cnt), .imm_valid(imm_valid), .imm_data(imm_data),
        .invert_first(invert_first), .result(result), .is_add(is_add),
        .carry_en(carry_en), .carry_done(carry_done), .op_ca(op_ca),
        .op_ca32(op_ca32), .oe_bit(oe_bit), .oe_valid(oe_valid),
        .divovf_valid(divovf_valid), .divovf_val(divovf_val), .rec_en(rec_en),
        .flag_so(flag_so), .flag_ov(flag_ov), .flag_ov32(flag_ov32),
        .flag_ca(flag_ca), .flag_ca32(flag_ca32), .cr0(cr0)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] c;
        logic [1:0]  cnt;
        logic        immv;
        logic [63:0] imm;
        logic        inv;
        logic [63:0] res;
        logic        add;
        logic        eca;
        logic        eca32;
    } cvec_t;

    localparam int NV = 11;
    localparam cvec_t CVEC [NV] = '{
        // R4 R5: 1+2=3, no carries
        '{64'd1, 64'd2, 64'd0, 2'd2, 1'b0, 64'd0, 1'b0, 64'd3, 1'b1, 1'b0, 1'b0},
        // R4 R5: all-ones + 1 wraps to 0
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 2'd2, 1'b0, 64'd0, 1'b0, 64'd0, 1'b1, 1'b1, 1'b1},
        // R5: carry out of low half only
        '{64'h0000_0000_FFFF_FFFF, 64'd1, 64'd0, 2'd2, 1'b0, 64'd0, 1'b0, 64'h1_0000_0000, 1'b1, 1'b0, 1'b1},
        // R6: low half greater, full not
        '{64'h0000_0001_0000_0005, 64'd0, 64'd0, 2'd1, 1'b0, 64'd0, 1'b0, 64'h0000_0002_0000_0003, 1'b0, 1'b0, 1'b1},
        // R6: full greater, low half not
        '{64'h0000_0003_0000_0001, 64'd0, 64'd0, 2'd1, 1'b0, 64'd0, 1'b0, 64'h0000_0001_0000_0002, 1'b0, 1'b1, 1'b0},
        // R3: inverted zero exceeds result
        '{64'd0, 64'd0, 64'd0, 2'd1, 1'b0, 64'd0, 1'b1, 64'h10, 1'b0, 1'b1, 1'b1},
        // R3 R5: complement-add form, 7 - 5 = 2
        '{64'd5, 64'd7, 64'd0, 2'd2, 1'b0, 64'd0, 1'b1, 64'd2, 1'b1, 1'b1, 1'b1},
        // R13: immediate greater than result
        '{64'd3, 64'd0, 64'd0, 2'd1, 1'b1, 64'h20, 1'b0, 64'h10, 1'b0, 1'b1, 1'b1},
        // R13: immediate takes slot 1 in the bit-32 rule
        '{64'd0, 64'hFFFF, 64'd0, 2'd1, 1'b1, 64'h1_0000_0000, 1'b0, 64'd0, 1'b1, 1'b1, 1'b1},
        // R4: third operand alone exceeds result
        '{64'd1, 64'd1, 64'h50, 2'd3, 1'b0, 64'd0, 1'b0, 64'h40, 1'b0, 1'b1, 1'b1},
        // R5: single operand, unused b bit 32 ignored
        '{64'h1_0000_0000, 64'h1_0000_0000, 64'd0, 2'd1, 1'b0, 64'd0, 1'b0, 64'h1_0000_0000, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        valid_in = 1'b0; reg_opnds = '0; reg_cnt = '0; imm_valid = 1'b0;
        imm_data = '0; invert_first = 1'b0; result = '0; is_add = 1'b0;
        carry_en = 1'b0; carry_done = '0; op_ca = 1'b0; op_ca32 = 1'b0;
        oe_bit = 1'b0; oe_valid = 1'b0; divovf_valid = 1'b0; divovf_val = 1'b0;
        rec_en = 1'b0;
    endtask

    // Hold valid_in for one cycle from a falling edge; return at the next one.
    task automatic pulse();
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic set_ops(input logic [63:0] a, input logic [63:0] b, input logic [63:0] r, input logic [1:0] n);
        reg_opnds = {64'd0, b, a};
        result = r;
        reg_cnt = n;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset flags", {flag_so, flag_ov, flag_ov32, flag_ca}, 4'h0);
        chk("R1 reset ca32/cr0", {flag_ca32, cr0[2:0]}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            idle_inputs();
            reg_opnds = {CVEC[i].c, CVEC[i].b, CVEC[i].a};
            reg_cnt = CVEC[i].cnt; imm_valid = CVEC[i].immv; imm_data = CVEC[i].imm;
            invert_first = CVEC[i].inv; result = CVEC[i].res; is_add = CVEC[i].add;
            carry_en = 1'b1;
            pulse();
            chk($sformatf("R4 R13 vector %0d ca", i), {3'b0, flag_ca}, {3'b0, CVEC[i].eca});
            chk($sformatf("R5 R6 vector %0d ca32", i), {3'b0, flag_ca32}, {3'b0, CVEC[i].eca32});
        end

        // Known state: ca=1, ca32=1 (wrap vector)
        idle_inputs(); carry_en = 1'b1; is_add = 1'b1;
        set_ops(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 2'd2);
        pulse();
        // R2: no valid, stimulus that would clear both
        idle_inputs(); carry_en = 1'b1; is_add = 1'b1;
        set_ops(64'd1, 64'd2, 64'd3, 2'd2);
        @(negedge clk);
        chk("R2 idle hold", {2'b0, flag_ca, flag_ca32}, 4'b0011);
        // R4: valid but carry disabled
        carry_en = 1'b0;
        pulse();
        chk("R4 carry_en low hold", {2'b0, flag_ca, flag_ca32}, 4'b0011);
        // R7: mask bit 0 supplies ca, ca32 computed (0)
        carry_en = 1'b1; carry_done = 2'b01; op_ca = 1'b1; op_ca32 = 1'b1;
        pulse();
        chk("R7 mask bit0", {2'b0, flag_ca, flag_ca32}, 4'b0010);
        // R7: mask bit 1 supplies ca32, ca computed (0)
        carry_done = 2'b10; op_ca = 1'b1; op_ca32 = 1'b1;
        pulse();
        chk("R7 mask bit1", {2'b0, flag_ca, flag_ca32}, 4'b0001);

        // R8: top-bit overflow, not at bit 31; summary set
        idle_inputs(); oe_bit = 1'b1; oe_valid = 1'b1;
        set_ops(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 2'd2);
        pulse();
        chk("R8 ov64 so", {1'b0, flag_so, flag_ov, flag_ov32}, 4'b0110);
        // R8 R11: bit-31 overflow only, summary stays
        set_ops(64'h7FFF_FFFF, 64'd1, 64'h8000_0000, 2'd2);
        pulse();
        chk("R8 R11 ov32 so", {1'b0, flag_so, flag_ov, flag_ov32}, 4'b0101);
        // R11: no overflow, summary still set
        set_ops(64'd1, 64'd2, 64'd3, 2'd2);
        pulse();
        chk("R11 sticky so", {1'b0, flag_so, flag_ov, flag_ov32}, 4'b0100);
        // R10: qualifier low blocks an overflowing case
        oe_valid = 1'b0;
        set_ops(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 2'd2);
        pulse();
        chk("R10 qualifier low", {1'b0, flag_so, flag_ov, flag_ov32}, 4'b0100);
        // R10: single slot without divide value blocks evaluation
        oe_valid = 1'b1; reg_cnt = 2'd1;
        reg_opnds = {64'd0, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF};
        pulse();
        chk("R10 one slot", {1'b0, flag_so, flag_ov, flag_ov32}, 4'b0100);
        // R9 R10: divide override with a single slot
        divovf_valid = 1'b1; divovf_val = 1'b1;
        pulse();
        chk("R9 div override 1", {1'b0, flag_so, flag_ov, flag_ov32}, 4'b0111);
        // R9: divide value 0 overrides an overflowing sign pattern
        divovf_val = 1'b0;
        set_ops(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_8000_0000, 2'd2);
        pulse();
        chk("R9 div override 0", {1'b0, flag_so, flag_ov, flag_ov32}, 4'b0100);

        // R1: reset in mid-run clears everything
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset flags", {flag_so, flag_ov, flag_ov32, flag_ca}, 4'h0);
        chk("R1 mid reset ca32", {3'b0, flag_ca32}, 4'h0);
        rst_n = 1'b1;

        // R12: summary set in the same update appears in cr0
        idle_inputs(); oe_bit = 1'b1; oe_valid = 1'b1; rec_en = 1'b1;
        set_ops(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 2'd2);
        pulse();
        chk("R12 negative with fresh so", cr0, 4'b1001);
        idle_inputs(); rec_en = 1'b1; result = 64'd0;
        pulse();
        chk("R12 zero", cr0, 4'b0011);
        result = 64'h42;
        pulse();
        chk("R12 positive", cr0, 4'b0101);
        // R12: record disabled holds cr0
        rec_en = 1'b0; result = 64'd0;
        pulse();
        chk("R12 hold", cr0, 4'b0101);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule